// File: doc/BRIEF.md
# Counter-Based Microsequencer with Return Stack

This block sequences a microprogrammed controller. A micro-address register and a ripple incrementer form a program counter. A three-way selector picks the next micro-address: the incremented address, a branch target held in the current microword, or an address taken from a small hardware return stack. The microword store is a table addressed by micro-address. Each word carries control outputs, a 2-bit sequencing operation, a target address and a select field. The select field names which status input decides a conditional branch.

The microword store is read synchronously with the next address. The control word and the sequencing fields therefore sit in a register that is always aligned with the micro-address register, which suits block RAM. Subroutine calls save the address after the call. Returns restore it, so the address after a return is known only at run time. Stack misuse raises sticky error flags.

Top module: `mseq`

## Requirements
- R1: While `rst` is high at a clock edge, `upc` becomes 0, `ctrl_out` takes the control field of word 0, both error flags clear and the return stack is emptied.
- R2: Operation code 00 (step) makes the next `upc` equal to `upc`+1, modulo 2^address-width.
- R3: Operation code 01 (conditional branch) jumps to the word's target when the selected condition is true. Select values 0..NSTAT-1 pick that bit of `status`, and select value NSTAT means always true.
- R4: A conditional branch whose condition is false falls through to `upc`+1.
- R5: Operation code 10 (call) pushes `upc`+1 on the return stack and jumps to the target.
- R6: Operation code 11 (return) pops the most recent saved address and continues there. Nested saves come back in last-in, first-out order.
- R7: `ctrl_out` is registered and always shows the control field of the word at the present `upc`, changing on the same edge as `upc`.
- R8: A call made while the stack already holds STK_DEPTH entries sets `err_ovf`, discards the push and still jumps to the target.
- R9: A return made with an empty stack sets `err_unf` and falls through to `upc`+1.
- R10: Both error flags stay set until the next reset.
- R11: The built-in microprogram has control field 0x10+address in words 0..14. The words are: 0 step; 1 call 8; 2 step; 3 call 8; 4 branch on status[0] to 13; 5 step; 6 branch on status[1] to 11; 7 branch always to 0; 8 step; 9 return; 11 call 11; 13 return; 14 branch always to 14. Unlisted words are steps with control 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| status | input | NSTAT (3) | Condition inputs for branches |
| ctrl_out | output | CTRL_W (8) | Control field of the current microword |
| upc | output | UA_W (4) | Current micro-address |
| err_ovf | output | 1 | Sticky: call into a full stack |
| err_unf | output | 1 | Sticky: return from an empty stack |

## Verification
A wrong saved address or stack pointer shows on `upc` one edge after the return word executes. The run then resumes at the wrong word, and `ctrl_out` leaves the expected 0x10+address pattern at once. A stack that reset fails to empty shows when a later top-level return jumps to a stale address instead of falling through with `err_unf` set. A wrong stack-level count shows when `err_ovf` rises one call too early or too late in the self-calling loop.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UA_W   = 4;
  localparam int CTRL_W = 8;
  localparam int NSTAT  = 3;
  localparam int SEL_W  = $clog2(NSTAT + 1);

  typedef enum logic [1:0] {
    OP_STEP = 2'b00,
    OP_BR   = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } seq_op_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    seq_op_e           op;
    logic [UA_W-1:0]   tgt;
    logic [SEL_W-1:0]  sel;
  } uword_t;

  localparam int SEL_ALWAYS = NSTAT;

  function automatic uword_t mk(input int addr, input seq_op_e op,
                                input int tgt, input int sel);
    uword_t w;
    w.ctrl = CTRL_W'(16 + addr);
    w.op   = op;
    w.tgt  = UA_W'(tgt);
    w.sel  = SEL_W'(sel);
    return w;
  endfunction

  // Microprogram: a subroutine at 8 called from 1 and 3, an underflow
  // exit at 13, and a self-calling loop at 11.
  function automatic uword_t rom_word(input logic [UA_W-1:0] a);
    uword_t w;
    case (int'(a))
      0:       w = mk(0,  OP_STEP, 0,  0);
      1:       w = mk(1,  OP_CALL, 8,  0);
      2:       w = mk(2,  OP_STEP, 0,  0);
      3:       w = mk(3,  OP_CALL, 8,  0);
      4:       w = mk(4,  OP_BR,   13, 0);
      5:       w = mk(5,  OP_STEP, 0,  0);
      6:       w = mk(6,  OP_BR,   11, 1);
      7:       w = mk(7,  OP_BR,   0,  SEL_ALWAYS);
      8:       w = mk(8,  OP_STEP, 0,  0);
      9:       w = mk(9,  OP_RET,  0,  0);
      11:      w = mk(11, OP_CALL, 11, 0);
      13:      w = mk(13, OP_RET,  0,  0);
      14:      w = mk(14, OP_BR,   14, SEL_ALWAYS);
      default: begin
        w      = mk(0, OP_STEP, 0, 0);
        w.ctrl = '0;
      end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/mseq_incr.sv
module mseq_incr #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  logic [W:0] carry;
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign y[i]       = a[i] ^ carry[i];
    assign carry[i+1] = a[i] & carry[i];
  end
endmodule

// File: rtl/mseq_stack.sv
module mseq_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [LW-1:0] lvl;
  logic          full;

  assign full  = (lvl == LW'(DEPTH));
  assign empty = (lvl == '0);
  assign dout  = empty ? '0 : mem[IW'(lvl - LW'(1))];

  always_ff @(posedge clk) begin
    if (!rst && push && !full) mem[IW'(lvl)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      lvl <= lvl + LW'(1);
    end else if (pop) begin
      if (empty) unf <= 1'b1;
      else       lvl <= lvl - LW'(1);
    end
  end
endmodule

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
(
  input  logic            clk,
  input  logic [UA_W-1:0] addr,
  output uword_t          word_q
);
  always_ff @(posedge clk) begin
    word_q <= rom_word(addr);
  end
endmodule

// File: rtl/mseq.sv
module mseq
  import mseq_pkg::*;
#(
  parameter int STK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTAT-1:0]  status,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [UA_W-1:0]   upc,
  output logic              err_ovf,
  output logic              err_unf
);
  localparam int CV_W = 2 ** SEL_W;

  uword_t            word_q;
  logic [UA_W-1:0]   pc_q, pc_inc, npc, rom_addr, pop_data;
  logic              stk_empty, do_push, do_pop, cond_hit;
  logic [CV_W-1:0]   cond_vec;

  mseq_incr #(.W(UA_W)) u_inc (.a(pc_q), .y(pc_inc));

  always_comb begin
    cond_vec           = '0;
    cond_vec[NSTAT-1:0] = status;
    cond_vec[NSTAT]    = 1'b1;
  end
  assign cond_hit = cond_vec[word_q.sel];

  assign do_push = (word_q.op == OP_CALL);
  assign do_pop  = (word_q.op == OP_RET);

  always_comb begin
    unique case (word_q.op)
      OP_STEP: npc = pc_inc;
      OP_BR:   npc = cond_hit ? word_q.tgt : pc_inc;
      OP_CALL: npc = word_q.tgt;
      OP_RET:  npc = stk_empty ? pc_inc : pop_data;
      default: npc = pc_inc;
    endcase
  end

  assign rom_addr = rst ? '0 : npc;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= npc;
  end

  mseq_rom u_rom (.clk(clk), .addr(rom_addr), .word_q(word_q));

  mseq_stack #(.W(UA_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop), .din(pc_inc),
    .dout(pop_data), .empty(stk_empty), .ovf(err_ovf), .unf(err_unf)
  );

  assign ctrl_out = word_q.ctrl;
  assign upc      = pc_q;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
  import mseq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW  = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic [UA_W-1:0] upc,
  input logic            err_ovf,
  input logic            err_unf,
  input seq_op_e         op_q,
  input logic [UA_W-1:0] tgt_q,
  input logic [LW-1:0]   lvl
);
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d)
      AST_RESET_HOME: assert (upc == '0 && !err_ovf && !err_unf && lvl == '0); // R1
  end

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    op_q == OP_STEP |=> upc == UA_W'($past(upc) + 1)); // R2

  AST_CALL_JUMP: assert property (@(posedge clk) disable iff (rst)
    op_q == OP_CALL |=> upc == $past(tgt_q)); // R5

  AST_RET_POPS: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_RET && lvl != '0) |=> lvl == LW'($past(lvl) - 1)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    lvl <= LW'(DEPTH)); // R8

  AST_UNF_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_RET && lvl == '0) |=> (err_unf && upc == UA_W'($past(upc) + 1))); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_ovf |=> err_ovf); // R10

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_unf |=> err_unf); // R10
endmodule

bind mseq mseq_chk #(.DEPTH(STK_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .upc(upc), .err_ovf(err_ovf), .err_unf(err_unf),
  .op_q(word_q.op), .tgt_q(word_q.tgt), .lvl(u_stk.lvl)
);

// File: tb/tb_mseq.sv
module tb_mseq;
  import mseq_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSTAT-1:0]  status = '0;
  logic [CTRL_W-1:0] ctrl_out;
  logic [UA_W-1:0]   upc;
  logic              err_ovf, err_unf;

  always #2 clk = ~clk;

  mseq #(.STK_DEPTH(4)) dut (
    .clk(clk), .rst(rst), .status(status), .ctrl_out(ctrl_out),
    .upc(upc), .err_ovf(err_ovf), .err_unf(err_unf)
  );

  // Expected address trace with all status low (R2 R4 R5 R6 R11)
  localparam int EXP_PC [16] = '{0, 1, 8, 9, 2, 3, 8, 9, 4, 5, 6, 7, 0, 1, 8, 9};

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    // Vector walk: two calls of one subroutine, each return resumes correctly
    status = 3'b000;
    do_reset();
    chk("R1 upc after reset", int'(upc), 0);
    chk("R1 ctrl after reset", int'(ctrl_out), 16);
    chk("R1 flags after reset", int'({err_ovf, err_unf}), 0);
    for (int i = 1; i < 16; i++) begin
      tick();
      chk("R2 R4 R5 R6 R11 upc trace", int'(upc), EXP_PC[i]);
      chk("R7 ctrl follows upc", int'(ctrl_out), 16 + EXP_PC[i]);
    end

    // Underflow: branch taken at 4 to a top-level return
    status = 3'b001;
    do_reset();
    repeat (9) tick();
    chk("R3 branch taken to 13", int'(upc), 13);
    chk("R9 no underflow yet", int'(err_unf), 0);
    tick();
    chk("R9 underflow falls through", int'(upc), 14);
    chk("R9 underflow flag", int'(err_unf), 1);
    chk("R7 ctrl at 14", int'(ctrl_out), 30);
    repeat (3) tick();
    chk("R10 underflow sticky", int'(err_unf), 1);
    chk("R3 always-branch holds 14", int'(upc), 14);
    chk("R8 no overflow on this path", int'(err_ovf), 0);

    // Overflow: branch not taken at 4, taken at 6, self-call at 11
    status = 3'b010;
    do_reset();
    repeat (11) tick();
    chk("R4 R3 path reaches 11", int'(upc), 11);
    repeat (4) tick();
    chk("R8 four pushes fit", int'(err_ovf), 0);
    chk("R5 call loops at 11", int'(upc), 11);
    tick();
    chk("R8 fifth push overflows", int'(err_ovf), 1);
    chk("R8 call still jumps", int'(upc), 11);
    status = 3'b000;
    repeat (2) tick();
    chk("R10 overflow sticky", int'(err_ovf), 1);

    // Reset clears flags and empties the full stack
    do_reset();
    chk("R1 flags cleared", int'({err_ovf, err_unf}), 0);
    chk("R1 upc cleared", int'(upc), 0);
    status = 3'b001;
    repeat (9) tick();
    chk("R3 reach 13 after reset", int'(upc), 13);
    tick();
    chk("R1 stack emptied: return falls through", int'(upc), 14);
    chk("R1 stack emptied: underflow raised", int'(err_unf), 1);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule